// File: doc/BRIEF.md
# Processor Presence Bitmap

The block keeps one bit per processor identifier, 256 by default, and lets software read the whole set as a byte-wide, read-only window. Identifier n is bit n%8 of byte n/8, so byte 0 holds identifiers 0 to 7 with identifier 0 in the least significant bit. Hardware reports processor arrival and departure through a one-cycle event strobe that carries an identifier and a plug/unplug flag. A valid event updates the matching bit. It also raises the processor-hotplug flag in the general-purpose event status byte, so that software knows to rescan the window.

After reset a two-state controller runs. In ST_LOAD the controller copies the boot-time presence mask into the bitmap. The transition LOAD_DONE then moves it to ST_RUN. Reset is the only path back to ST_LOAD, and ST_RUN returns to itself (RUN_HOLD). Events are applied only in ST_RUN. A window access with the write qualifier set is accepted but has no effect. An event whose identifier lies beyond the bitmap leaves everything unchanged and produces a one-cycle error pulse.

Top module: `cpu_presence_map`

## Requirements
- R1: The first clock edge after reset is released runs state ST_LOAD, which copies `boot_mask` into the bitmap. Every later edge runs ST_RUN. An event presented on that first edge is dropped.
- R2: A read access (`acc_en`=1, `acc_we`=0, `acc_addr`=a) returns byte a on `rd_data` one cycle later. Bit k of byte a is identifier 8a+k. Between reads `rd_data` holds its value.
- R3: An event with `ev_valid`=1, `ev_plug`=1 and `ev_id` below 256 sets that identifier's bit from the next cycle on.
- R4: An event with `ev_valid`=1, `ev_plug`=0 and `ev_id` below 256 clears that identifier's bit from the next cycle on.
- R5: Every accepted plug or unplug event sets bit 2 of `gpe_sts` (value 0x04) from the next cycle on. All other bits of `gpe_sts` are always 0.
- R6: `gpe_clr`=1 clears the flag on the next cycle. If an accepted event arrives in the same cycle as the clear, the event wins and the flag stays set.
- R7: A read in the same cycle as an event that touches the same byte returns the byte as it was before the event.
- R8: An access with `acc_we`=1 changes neither the bitmap nor `rd_data`.
- R9: An event with `ev_id` of 256 or more changes neither the bitmap nor `gpe_sts`. It drives `id_err` high for exactly the next cycle.
- R10: While reset is asserted, `rd_data` is 0x00, `gpe_sts` is 0x00 and `id_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mask | input | 256 | Processors present at boot, loaded in ST_LOAD |
| ev_valid | input | 1 | Event strobe |
| ev_plug | input | 1 | 1 = plug, 0 = unplug |
| ev_id | input | 9 | Processor identifier of the event |
| acc_en | input | 1 | Window access strobe |
| acc_we | input | 1 | Access is a write (ignored) |
| acc_addr | input | 5 | Byte index within the window |
| rd_data | output | 8 | Registered read byte |
| gpe_clr | input | 1 | Clears the processor-hotplug status flag |
| gpe_sts | output | 8 | Event status byte, flag at bit 2 |
| id_err | output | 1 | One-cycle pulse after an out-of-range event |

## Verification
Two pairs of functions can fall in the same cycle. In the first, an event and a read address the same byte. The bench drives both on one edge and expects `rd_data` to show the byte before the event; a second read must then show the updated byte. In the second, an event and a status clear coincide. The bench expects the flag still set and checks that a lone clear on the following cycle does drop it.

// File: rtl/cpu_presence_pkg.sv
package cpu_presence_pkg;
    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic upd;
        logic plug;
    } map_op_t;
endpackage

// File: rtl/cpu_event_decode.sv
module cpu_event_decode #(
    parameter int NUM_IDS = 256,
    parameter int ID_W    = 9,
    localparam int IDX_W  = $clog2(NUM_IDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic                          ev_valid,
    input  logic                          ev_plug,
    input  logic [ID_W-1:0]               ev_id,
    output cpu_presence_pkg::map_op_t     op,
    output logic [IDX_W-1:0]              idx,
    output logic                          id_err
);
    localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_IDS);

    logic in_range;
    logic bad_now;

    assign in_range = ({1'b0, ev_id} < LIMIT);
    assign idx      = ev_id[IDX_W-1:0];
    assign op.upd   = accept && ev_valid && in_range;
    assign op.plug  = ev_plug;
    assign bad_now  = accept && ev_valid && !in_range;

    always_ff @(posedge clk) begin
        if (!rst_n) id_err <= 1'b0;
        else        id_err <= bad_now;
    end

    // R9: an out-of-range identifier produces a pulse on the next cycle
    p_bad_id_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev_valid && (ev_id >= ID_W'(NUM_IDS))) |=> id_err);
    // R9: the pulse never follows a cycle without a bad event
    p_err_needs_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && ev_valid && (ev_id >= ID_W'(NUM_IDS))) |=> !id_err);
endmodule

// File: rtl/cpu_map_store.sv
module cpu_map_store #(
    parameter int NUM_IDS   = 256,
    localparam int IDX_W    = $clog2(NUM_IDS),
    localparam int NBYTES   = NUM_IDS / 8,
    localparam int ADDR_W   = $clog2(NBYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_en,
    input  logic [NUM_IDS-1:0]        boot_mask,
    input  cpu_presence_pkg::map_op_t op,
    input  logic [IDX_W-1:0]          idx,
    input  logic                      acc_en,
    input  logic                      acc_we,
    input  logic [ADDR_W-1:0]         acc_addr,
    output logic [7:0]                rd_data
);
    logic [NUM_IDS-1:0] map_q;
    logic [7:0]         byte_view [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
        assign byte_view[g] = map_q[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (load_en) begin
            map_q <= boot_mask;
        end else if (op.upd) begin
            map_q[idx] <= op.plug;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
        end else if (acc_en && !acc_we) begin
            rd_data <= byte_view[acc_addr];
        end
    end

    // R3: plug sets the addressed bit
    p_plug_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op.upd && op.plug && !load_en) |=> map_q[$past(idx)]);
    // R4: unplug clears the addressed bit
    p_unplug_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op.upd && !op.plug && !load_en) |=> !map_q[$past(idx)]);
    // R7: a read returns the byte held before the edge
    p_read_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> rd_data == $past(map_q[{acc_addr, 3'b000} +: 8]));
    // R8: without load or event the bitmap holds
    p_quiet_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !op.upd) |=> $stable(map_q));
    // R8: a write access leaves the read register alone
    p_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(acc_en && !acc_we)) |=> $stable(rd_data));
endmodule

// File: rtl/cpu_gpe_flag.sv
module cpu_gpe_flag #(
    parameter int GPE_BIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set,
    input  logic       clr,
    output logic [7:0] gpe_sts
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    always_comb begin
        gpe_sts          = 8'h00;
        gpe_sts[GPE_BIT] = flag_q;
    end

    // R5: every accepted event raises the flag
    p_evt_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> gpe_sts[GPE_BIT]);
    // R6: a clear without a concurrent event drops the flag
    p_clr_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !gpe_sts[GPE_BIT]);
    // R5: only one status bit is ever driven
    p_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gpe_sts) <= 1);
endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
    parameter int NUM_IDS  = 256,
    parameter int ID_W     = 9,
    parameter int GPE_BIT  = 2,
    localparam int IDX_W   = $clog2(NUM_IDS),
    localparam int NBYTES  = NUM_IDS / 8,
    localparam int ADDR_W  = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IDS-1:0]   boot_mask,
    input  logic                 ev_valid,
    input  logic                 ev_plug,
    input  logic [ID_W-1:0]      ev_id,
    input  logic                 acc_en,
    input  logic                 acc_we,
    input  logic [ADDR_W-1:0]    acc_addr,
    output logic [7:0]           rd_data,
    input  logic                 gpe_clr,
    output logic [7:0]           gpe_sts,
    output logic                 id_err
);
    import cpu_presence_pkg::*;

    ctl_state_t state_q, state_d;
    logic       load_en;
    logic       accept;
    map_op_t    op;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                load_en = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                accept  = 1'b1;
                state_d = ST_RUN;
            end
            default: state_d = ST_LOAD;
        endcase
    end

    cpu_event_decode #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .ev_valid (ev_valid),
        .ev_plug  (ev_plug),
        .ev_id    (ev_id),
        .op       (op),
        .idx      (idx),
        .id_err   (id_err)
    );

    cpu_map_store #(.NUM_IDS(NUM_IDS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .boot_mask (boot_mask),
        .op        (op),
        .idx       (idx),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .rd_data   (rd_data)
    );

    cpu_gpe_flag #(.GPE_BIT(GPE_BIT)) u_gpe (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (op.upd),
        .clr     (gpe_clr),
        .gpe_sts (gpe_sts)
    );

    // R1: once running, the controller never returns to loading
    p_run_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));
    // R1: loading lasts one cycle
    p_load_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_RUN));
    // R1: no event is applied while loading
    p_no_evt_in_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> !op.upd);
endmodule

// File: tb/test_cpu_presence_map.sv
module test_cpu_presence_map;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] boot_mask;
    logic         ev_valid = 1'b0, ev_plug = 1'b0;
    logic [8:0]   ev_id = '0;
    logic         acc_en = 1'b0, acc_we = 1'b0;
    logic [4:0]   acc_addr = '0;
    logic [7:0]   rd_data;
    logic         gpe_clr = 1'b0;
    logic [7:0]   gpe_sts;
    logic         id_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cpu_presence_map i_cpu_presence_map (
        .clk(clk), .rst_n(rst_n), .boot_mask(boot_mask),
        .ev_valid(ev_valid), .ev_plug(ev_plug), .ev_id(ev_id),
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
        .rd_data(rd_data), .gpe_clr(gpe_clr), .gpe_sts(gpe_sts),
        .id_err(id_err)
    );

    // vector: [22] plug, [21:13] id, [12:8] byte to read, [7:0] expected byte
    localparam int NV = 8;
    localparam logic [22:0] VECS [NV] = '{
        {1'b1, 9'd5,   5'd0,  8'h23},
        {1'b1, 9'd9,   5'd1,  8'h02},
        {1'b0, 9'd0,   5'd0,  8'h22},
        {1'b1, 9'd254, 5'd31, 8'hC0},
        {1'b0, 9'd255, 5'd31, 8'h40},
        {1'b1, 9'd100, 5'd12, 8'h10},
        {1'b1, 9'd103, 5'd12, 8'h90},
        {1'b0, 9'd9,   5'd1,  8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic event_go(input logic plug, input logic [8:0] id);
        @(negedge clk);
        ev_valid = 1'b1; ev_plug = plug; ev_id = id;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic read_byte(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_en = 1'b0;
        v = rd_data;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        gpe_clr = 1'b1;
        @(negedge clk);
        gpe_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ev_valid = 1'b0; acc_en = 1'b0; gpe_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        boot_mask = '0;
        boot_mask[0] = 1'b1; boot_mask[1] = 1'b1; boot_mask[255] = 1'b1;
        do_reset();
        // R10 reset values
        check("R10 rd_data", rd_data, 8'h00);
        check("R10 gpe_sts", gpe_sts, 8'h00);
        check("R10 id_err", {7'd0, id_err}, 8'h00);

        // R1: event in the load cycle is dropped
        ev_valid = 1'b1; ev_plug = 1'b1; ev_id = 9'd2;
        rst_n = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        check("R1 no flag from load-cycle event", gpe_sts, 8'h00);
        read_byte(5'd0, v);  check("R1 boot byte0", v, 8'h03);
        read_byte(5'd31, v); check("R1 boot byte31", v, 8'h80);

        // R2 R3 R4 R5: table walk
        for (int i = 0; i < NV; i++) begin
            event_go(VECS[i][22], VECS[i][21:13]);
            check("R5 flag after event", gpe_sts, 8'h04);
            read_byte(VECS[i][12:8], v);
            check(VECS[i][22] ? "R3 plug byte" : "R4 unplug byte", v, VECS[i][7:0]);
            clear_flag();
        end
        check("R6 clear drops flag", gpe_sts, 8'h00);

        // R6: event and clear in the same cycle
        @(negedge clk);
        ev_valid = 1'b1; ev_plug = 1'b1; ev_id = 9'd40; gpe_clr = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; gpe_clr = 1'b0;
        check("R6 event beats clear", gpe_sts, 8'h04);
        clear_flag();
        check("R6 later clear", gpe_sts, 8'h00);

        // R7: read and event on the same byte in the same cycle
        @(negedge clk);
        ev_valid = 1'b1; ev_plug = 1'b1; ev_id = 9'd41;
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = 5'd5;
        @(negedge clk);
        ev_valid = 1'b0; acc_en = 1'b0;
        check("R7 read before event", rd_data, 8'h01);
        read_byte(5'd5, v); check("R7 read after event", v, 8'h03);
        clear_flag();

        // R8: write access ignored
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = 5'd0;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        check("R8 rd_data held on write", rd_data, 8'h03);
        read_byte(5'd0, v); check("R8 byte0 unchanged", v, 8'h22);

        // R9: out-of-range identifier
        event_go(1'b1, 9'd256);
        check("R9 id_err pulse", {7'd0, id_err}, 8'h01);
        check("R9 no flag", gpe_sts, 8'h00);
        @(negedge clk);
        check("R9 pulse ends", {7'd0, id_err}, 8'h00);
        event_go(1'b0, 9'd511);
        check("R9 second bad id", {7'd0, id_err}, 8'h01);
        read_byte(5'd0, v);  check("R9 byte0 kept", v, 8'h22);
        read_byte(5'd31, v); check("R9 byte31 kept", v, 8'h40);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule